// File: doc/BRIEF.md
# Configurable Sum-of-Products Term Array

This block evaluates a reconfigurable two-level logic function. Ten dedicated inputs and eight feedback signals are expanded into 36 array lines, one true copy and one inverted copy of each signal. A connection plane selects which lines each of 113 product terms depends on. A term is the AND of its selected lines. The first 102 terms are split into eight unequal groups, and each group is ORed into one sum output. Of the remaining eleven terms, eight drive per-output enables and three drive global terms: a synchronous preset, an asynchronous clear and a clock.

The connection plane is written through a one-bit serial chain. The chain fills while a shift enable is high. It has no effect on the outputs until a commit strobe copies the whole chain into the live plane in one cycle. An erase strobe opens every connection in both the chain and the live plane. An unused term is silenced by connecting it to both copies of one signal.

All outputs are registered, so each output reflects the inputs and the live plane at the preceding rising clock edge.

Top module: `sop_term_array`

## Requirements
- R1: While `rst` is high at a rising edge, every output register clears to 0. The chain and the live plane return to the erased state, with every connection open.
- R2: Line 2i carries `in_pins[i]` and line 2i+1 carries its inverse. Line 20+2j carries `fb_pins[j]` and line 21+2j carries its inverse. A connection bit of 1 joins a line to a term. A term is TRUE when every line joined to it is 1.
- R3: While `cfg_shift` is high and `cfg_erase` is low, `cfg_data` enters the chain at flat index 0 and every other bit moves up one place. Flat index = term*36 + line, so after 4068 shifts the first bit sent sits at term 112, line 35.
- R4: Shifting alone leaves the outputs unchanged. `cfg_commit` copies the chain into the live plane. When a shift and a commit fall in the same cycle, the copy takes the chain contents from before that shift.
- R5: `cfg_erase` opens every connection in the chain and in the live plane in one cycle, and it overrides a commit or a shift in the same cycle.
- R6: A term with no connection is TRUE, so after an erase every output is 1.
- R7: A term joined to both the true line and the inverted line of one signal is always FALSE, so it adds nothing to its OR group.
- R8: `sum_out[g]` is the OR of consecutive terms taken in group sizes 16, 14, 12, 10, 10, 12, 14 and 14, starting at term 0. Terms 102 to 109 drive `oe_out[0..7]`, term 110 drives `preset_term`, term 111 drives `clear_term` and term 112 drives `clock_term`.
- R9: Outputs change exactly one rising edge after the inputs or the live plane that produce them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_pins | input | 10 | Dedicated input signals |
| fb_pins | input | 8 | Feedback or pin signals |
| cfg_shift | input | 1 | Shifts `cfg_data` into the chain |
| cfg_data | input | 1 | Serial connection bit |
| cfg_commit | input | 1 | Copies the chain into the live plane |
| cfg_erase | input | 1 | Opens every connection |
| sum_out | output | 8 | Registered OR of each term group |
| oe_out | output | 8 | Registered per-output enable terms |
| preset_term | output | 1 | Registered synchronous-preset term |
| clear_term | output | 1 | Registered asynchronous-clear term |
| clock_term | output | 1 | Registered clock term |

## Verification
Commit can fall in the same cycle as shift, and erase can fall in the same cycle as commit. The bench loads a full plane and then raises shift and commit together. The outputs must then follow the plane loaded before that last shift. In a separate cycle the bench raises erase, commit and shift at once. It then checks that every output reads 1, and that a later commit still leaves every output at 1, which shows the chain was erased as well.

// File: rtl/sop_array_pkg.sv
`timescale 1ns/1ps
package sop_array_pkg;
  localparam int unsigned DED_DEF  = 10;
  localparam int unsigned FB_DEF   = 8;
  localparam int unsigned GLOB_CNT = 3;
  // group g size lives in bits [8g+7:8g]
  localparam logic [63:0] GRP_SIZES_DEF =
    {8'd14, 8'd14, 8'd12, 8'd10, 8'd10, 8'd12, 8'd14, 8'd16};

  // first term index of group g (sum of the sizes before it)
  function automatic int unsigned grp_offset(input logic [255:0] sizes,
                                             input int unsigned g);
    int unsigned acc;
    acc = 0;
    for (int unsigned i = 0; i < g; i++) acc = acc + 32'(sizes[i*8 +: 8]);
    return acc;
  endfunction
endpackage

// File: rtl/sop_cfg_chain.sv
`timescale 1ns/1ps
module sop_cfg_chain #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  input  logic         erase,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || erase) q <= '0;
    else if (shift_en) q <= {q[W-2:0], din};
  end

  a_r3_shift_in: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !erase) |=> (q[0] == $past(din)) && (q[W-1:1] == $past(q[W-2:0])));

  a_r5_chain_erased: assert property (@(posedge clk) disable iff (rst)
    erase |=> (q == '0));
endmodule

// File: rtl/sop_plane_reg.sv
`timescale 1ns/1ps
module sop_plane_reg #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         commit,
  input  logic         erase,
  input  logic [W-1:0] shadow,
  output logic [W-1:0] plane
);
  always_ff @(posedge clk) begin
    if (rst || erase) plane <= '0;
    else if (commit) plane <= shadow;
  end

  a_r4_commit_copies: assert property (@(posedge clk) disable iff (rst)
    (commit && !erase) |=> (plane == $past(shadow)));

  a_r4_hold_without_commit: assert property (@(posedge clk) disable iff (rst)
    (!commit && !erase) |=> $stable(plane));

  a_r5_plane_erased: assert property (@(posedge clk) disable iff (rst)
    erase |=> (plane == '0));
endmodule

// File: rtl/sop_line_drv.sv
`timescale 1ns/1ps
module sop_line_drv #(
  parameter int unsigned N_DED = 10,
  parameter int unsigned N_FB  = 8,
  localparam int unsigned N_LINES = 2 * (N_DED + N_FB)
) (
  input  logic [N_DED-1:0]   ded,
  input  logic [N_FB-1:0]    fb,
  output logic [N_LINES-1:0] lines
);
  for (genvar i = 0; i < N_DED; i++) begin : g_ded
    assign lines[2*i]   = ded[i];
    assign lines[2*i+1] = ~ded[i];
  end
  for (genvar j = 0; j < N_FB; j++) begin : g_fb
    assign lines[2*N_DED + 2*j]     = fb[j];
    assign lines[2*N_DED + 2*j + 1] = ~fb[j];
  end
endmodule

// File: rtl/sop_and_plane.sv
`timescale 1ns/1ps
module sop_and_plane #(
  parameter int unsigned N_LINES = 36,
  parameter int unsigned N_TERMS = 113,
  localparam int unsigned W = N_LINES * N_TERMS
) (
  input  logic [N_LINES-1:0] lines,
  input  logic [W-1:0]       plane,
  output logic [N_TERMS-1:0] terms
);
  // open connection (0) lets a line through as don't-care
  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    assign terms[t] = &(~plane[t*N_LINES +: N_LINES] | lines);
  end
endmodule

// File: rtl/sop_or_plane.sv
`timescale 1ns/1ps
module sop_or_plane #(
  parameter int unsigned N_OUT = 8,
  parameter logic [N_OUT*8-1:0] GRP_SIZES = sop_array_pkg::GRP_SIZES_DEF,
  localparam int unsigned N_SUM = sop_array_pkg::grp_offset(256'(GRP_SIZES), N_OUT)
) (
  input  logic [N_SUM-1:0] terms,
  output logic [N_OUT-1:0] sums
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_grp
    localparam int unsigned OFF = sop_array_pkg::grp_offset(256'(GRP_SIZES), g);
    localparam int unsigned SZ  = 32'(GRP_SIZES[g*8 +: 8]);
    assign sums[g] = |terms[OFF +: SZ];
  end
endmodule

// File: rtl/sop_term_array.sv
`timescale 1ns/1ps
module sop_term_array #(
  parameter int unsigned N_DED = sop_array_pkg::DED_DEF,
  parameter int unsigned N_FB  = sop_array_pkg::FB_DEF,
  parameter logic [N_FB*8-1:0] GRP_SIZES = sop_array_pkg::GRP_SIZES_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_DED-1:0] in_pins,
  input  logic [N_FB-1:0]  fb_pins,
  input  logic            cfg_shift,
  input  logic            cfg_data,
  input  logic            cfg_commit,
  input  logic            cfg_erase,
  output logic [N_FB-1:0]  sum_out,
  output logic [N_FB-1:0]  oe_out,
  output logic            preset_term,
  output logic            clear_term,
  output logic            clock_term
);
  localparam int unsigned N_LINES = 2 * (N_DED + N_FB);
  localparam int unsigned N_SUM   = sop_array_pkg::grp_offset(256'(GRP_SIZES), N_FB);
  localparam int unsigned N_TERMS = N_SUM + N_FB + sop_array_pkg::GLOB_CNT;
  localparam int unsigned CFG_W   = N_TERMS * N_LINES;
  localparam int unsigned T_OE    = N_SUM;
  localparam int unsigned T_PRE   = N_SUM + N_FB;
  localparam int unsigned T_CLR   = T_PRE + 1;
  localparam int unsigned T_CLK   = T_PRE + 2;

  logic [CFG_W-1:0]   chain_q;
  logic [CFG_W-1:0]   plane_q;
  logic [N_LINES-1:0] lines;
  logic [N_TERMS-1:0] terms;
  logic [N_FB-1:0]    sums_c;

  sop_cfg_chain #(.W(CFG_W)) u_chain (
    .clk(clk), .rst(rst), .shift_en(cfg_shift), .din(cfg_data),
    .erase(cfg_erase), .q(chain_q)
  );

  sop_plane_reg #(.W(CFG_W)) u_plane (
    .clk(clk), .rst(rst), .commit(cfg_commit), .erase(cfg_erase),
    .shadow(chain_q), .plane(plane_q)
  );

  sop_line_drv #(.N_DED(N_DED), .N_FB(N_FB)) u_lines (
    .ded(in_pins), .fb(fb_pins), .lines(lines)
  );

  sop_and_plane #(.N_LINES(N_LINES), .N_TERMS(N_TERMS)) u_and (
    .lines(lines), .plane(plane_q), .terms(terms)
  );

  sop_or_plane #(.N_OUT(N_FB), .GRP_SIZES(GRP_SIZES)) u_or (
    .terms(terms[N_SUM-1:0]), .sums(sums_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_out     <= '0;
      oe_out      <= '0;
      preset_term <= 1'b0;
      clear_term  <= 1'b0;
      clock_term  <= 1'b0;
    end else begin
      sum_out     <= sums_c;
      oe_out      <= terms[T_OE +: N_FB];
      preset_term <= terms[T_PRE];
      clear_term  <= terms[T_CLR];
      clock_term  <= terms[T_CLK];
    end
  end

  a_r6_open_plane_all_true: assert property (@(posedge clk) disable iff (rst)
    (plane_q == '0) |=> ((sum_out == '1) && (oe_out == '1) &&
                         preset_term && clear_term && clock_term));

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> ((sum_out == '0) && (oe_out == '0) &&
             !preset_term && !clear_term && !clock_term));
endmodule

// File: tb/test_sop_term_array.sv
`timescale 1ns/1ps
module test_sop_term_array;
  localparam int NL = 36;
  localparam int NT = 113;
  localparam int NS = 102;
  localparam int CW = NT * NL;
  localparam int GS [8] = '{16, 14, 12, 10, 10, 12, 14, 14};

  typedef struct {
    int         due;
    logic [7:0] s;
    logic [7:0] o;
    logic       p, c, k;
    string      req;
  } exp_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1;
  logic [9:0] in_pins = '0;
  logic [7:0] fb_pins = '0;
  logic       cfg_shift = 1'b0, cfg_data = 1'b0, cfg_commit = 1'b0, cfg_erase = 1'b0;
  logic [7:0] sum_out, oe_out;
  logic       preset_term, clear_term, clock_term;

  sop_term_array i_sop_term_array (
    .clk(clk), .rst(rst), .in_pins(in_pins), .fb_pins(fb_pins),
    .cfg_shift(cfg_shift), .cfg_data(cfg_data), .cfg_commit(cfg_commit),
    .cfg_erase(cfg_erase), .sum_out(sum_out), .oe_out(oe_out),
    .preset_term(preset_term), .clear_term(clear_term), .clock_term(clock_term)
  );

  int nchk = 0, nerr = 0, cyc = 0;
  bit done = 0;
  int off [8];
  logic [NL-1:0] pend  [NT];
  logic [NL-1:0] act_m [NT];
  exp_t q [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference from R2, R6, R7, R8
  function automatic exp_t model(logic [9:0] di, logic [7:0] fi);
    exp_t e;
    logic [NL-1:0] ln;
    logic [NT-1:0] tv;
    for (int i = 0; i < 10; i++) begin ln[2*i] = di[i]; ln[2*i+1] = ~di[i]; end
    for (int j = 0; j < 8; j++) begin ln[20+2*j] = fi[j]; ln[21+2*j] = ~fi[j]; end
    for (int t = 0; t < NT; t++) tv[t] = ((act_m[t] & ~ln) == '0);
    for (int g = 0; g < 8; g++) begin
      e.s[g] = 1'b0;
      for (int m = 0; m < GS[g]; m++) e.s[g] = e.s[g] | tv[off[g] + m];
      e.o[g] = tv[NS + g];
    end
    e.p = tv[NS + 8];
    e.c = tv[NS + 9];
    e.k = tv[NS + 10];
    return e;
  endfunction

  // driver: applies a pattern and queues what must appear one edge later (R9)
  task automatic drive(logic [9:0] di, logic [7:0] fi, string req);
    exp_t e;
    @(negedge clk);
    in_pins = di;
    fb_pins = fi;
    e = model(di, fi);
    e.due = cyc + 1;
    e.req = req;
    q.push_back(e);
  endtask

  // monitor: pops expectations at their due cycle
  always @(negedge clk) begin
    exp_t e;
    while (q.size() > 0 && q[0].due == cyc) begin
      e = q.pop_front();
      chk(e.req, "sum_out", sum_out, e.s);
      chk(e.req, "oe_out", oe_out, e.o);
      chk(e.req, "globals", {5'b0, preset_term, clear_term, clock_term}, {5'b0, e.p, e.c, e.k});
    end
  end

  task automatic shift_all();
    for (int k = 0; k < CW; k++) begin
      @(negedge clk);
      cfg_shift = 1'b1;
      cfg_data  = pend[(CW-1-k) / NL][(CW-1-k) % NL];
    end
    @(negedge clk);
    cfg_shift = 1'b0;
    cfg_data  = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk);
    cfg_commit = 1'b1;
    @(negedge clk);
    cfg_commit = 1'b0;
    for (int t = 0; t < NT; t++) act_m[t] = pend[t];
  endtask

  task automatic erase_model();
    for (int t = 0; t < NT; t++) act_m[t] = '0;
  endtask

  task automatic chk_zero(string req);
    chk(req, "sum_out", sum_out, 8'h00);
    chk(req, "oe_out", oe_out, 8'h00);
    chk(req, "globals", {5'b0, preset_term, clear_term, clock_term}, 8'h00);
  endtask

  // every term of every group silenced by the R7 pattern (lines 0 and 1)
  task automatic silence_all();
    for (int t = 0; t < NT; t++) pend[t] = 36'h3;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    off[0] = 0;
    for (int g = 1; g < 8; g++) off[g] = off[g-1] + GS[g-1];
    erase_model();

    // R1: reset clears the outputs
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_zero("R1");
    rst = 1'b0;

    // R6: erased plane, every term TRUE
    drive(10'h3FF, 8'hFF, "R6");
    drive(10'h000, 8'h00, "R6");

    // program A
    silence_all();
    for (int g = 0; g < 8; g++) begin
      pend[off[g]] = '0;
      pend[off[g]][2*g] = 1'b1;          // in_pins[g]
      pend[off[g]][21+2*g] = 1'b1;       // ~fb_pins[g]
    end
    pend[off[0]+1] = '0;
    pend[off[0]+1][18] = 1'b1;           // in_pins[9] alone
    for (int k = 0; k < 8; k++) begin
      pend[NS+k] = '0;
      pend[NS+k][20+2*k] = 1'b1;         // fb_pins[k]
    end
    pend[NS+8] = '0; pend[NS+8][16] = 1'b1; pend[NS+8][18] = 1'b1;
    pend[NS+9] = 36'h3;                  // clear silenced
    pend[NS+10] = '0; pend[NS+10][1] = 1'b1;
    shift_all();

    // R4: loaded but not committed, still erased behaviour
    drive(10'h155, 8'h0F, "R4");
    commit();

    drive(10'h000, 8'h00, "R3");
    drive(10'h3FF, 8'hFF, "R2");
    drive(10'h155, 8'h0F, "R8");
    drive(10'h2AA, 8'hA5, "R7");
    drive(10'h0FF, 8'h00, "R9");
    drive(10'h300, 8'hFF, "R9");

    // R1: reset mid-run returns the plane to erased
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk_zero("R1");
    rst = 1'b0;
    erase_model();
    drive(10'h000, 8'h00, "R1");

    // program B: only the last term of each group is live
    silence_all();
    for (int g = 0; g < 8; g++) begin
      pend[off[g] + GS[g] - 1] = '0;
      pend[off[g] + GS[g] - 1][2*g] = 1'b1;
      pend[off[g] + GS[g] - 1][20+2*(7-g)] = 1'b1;
    end
    pend[NS+8] = '0;                     // open: TRUE
    pend[NS+9] = '0; pend[NS+9][21] = 1'b1;
    pend[NS+10] = '0; pend[NS+10][20] = 1'b1; pend[NS+10][21] = 1'b1;
    shift_all();

    // R4: shift and commit together, commit uses the pre-shift chain
    @(negedge clk);
    cfg_shift = 1'b1; cfg_data = 1'b1; cfg_commit = 1'b1;
    @(negedge clk);
    cfg_shift = 1'b0; cfg_data = 1'b0; cfg_commit = 1'b0;
    for (int t = 0; t < NT; t++) act_m[t] = pend[t];
    drive(10'h0FF, 8'hFF, "R4");
    drive(10'h0F0, 8'h0F, "R8");
    drive(10'h0AA, 8'hAA, "R7");
    drive(10'h3FF, 8'h01, "R6");

    // R5: erase with commit and shift in the same cycle
    @(negedge clk);
    cfg_erase = 1'b1; cfg_commit = 1'b1; cfg_shift = 1'b1; cfg_data = 1'b1;
    @(negedge clk);
    cfg_erase = 1'b0; cfg_commit = 1'b0; cfg_shift = 1'b0; cfg_data = 1'b0;
    erase_model();
    drive(10'h000, 8'hFF, "R5");
    for (int t = 0; t < NT; t++) pend[t] = '0;
    commit();                            // chain was erased too
    drive(10'h155, 8'h55, "R5");

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      nchk++; nerr++;
      $display("FAIL R9 pending: actual %0d expected 0", q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule